// File: doc/BRIEF.md
# Shift-Add Serial-Parallel Multiplier

This block forms the unsigned product of two small operands one multiplier bit at a time. A single accumulator register, one bit wider than the product, holds both the multiplier and the growing partial sum. When a start pulse arrives while the block is idle, the multiplier goes into the low half of the accumulator, the upper part is cleared and the multiplicand is captured in its own register.

The sequencer then inspects the accumulator's least significant bit. If that bit is 1, it first adds the multiplicand into the upper accumulator bits and then shifts. If it is 0, it only shifts. Each shift moves the whole accumulator right by one place. The consumed multiplier bit drops out at the bottom, and the carry of the last add moves down into the partial sum.

A separate step counter counts the shifts. It raises a completion flag on the final shift, and the sequencer then gives a one-cycle done pulse. The product is read from the low bits of the accumulator and stays there until the next start.

Top module: `smul_top`

## Requirements
- R1: While reset is high, and on the cycle after it falls, `done` is 0 and `product` is 0.
- R2: After the done pulse, `product` equals the unsigned product `mcand_in * mplier_in` of the operands sampled with start, for all 256 pairs of 4-bit operands (15 x 15 gives 225).
- R3: A start sampled while idle loads the accumulator in one edge with the upper 5 bits cleared and the low 4 bits set to the multiplier. On the following cycle `product` reads `{4'b0000, mplier_in}`.
- R4: An add cycle stores the upper 4 accumulator bits plus the multiplicand, including the carry, into the upper 5 accumulator bits and leaves the low 4 bits unchanged. For multiplicand 15 and multiplier 1, `product` is 8'hF1 one edge after the load.
- R5: A shift cycle moves all 9 accumulator bits right by one place, with a 0 entering at the top and any add carry moving down into bit 7. For multiplicand 15 and multiplier 15, `product` is 8'hB7 four edges after the load.
- R6: A multiplier bit of 1 costs an add cycle followed by a shift cycle, and a bit of 0 costs only a shift cycle. `done` therefore rises 4 + (number of 1 bits in the multiplier) edges after the edge that samples start.
- R7: The step counter flags completion on the 4th shift. `done` is then high for exactly one cycle, and the block returns to idle.
- R8: A start pulse, or a change of the operand inputs, while an operation is in progress has no effect on the result or on its timing.
- R9: After the done pulse, `product` holds its value and `done` stays 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand_in | input | 4 | Multiplicand, sampled with start |
| mplier_in | input | 4 | Multiplier, sampled with start |
| product | output | 8 | Low accumulator bits; the product after done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is an add whose carry runs into bit 8 of the accumulator, because only the final product shows it, after it has been shifted down. A directed run with both operands at 15 samples `product` edge by edge after the load. The intermediate value 8'hB7 can only appear if the carry was stored and then moved down by the shift. Starts and operand changes injected during a run show that nothing outside idle reaches the datapath. An exhaustive sweep checks the cycle count of every multiplier's bit pattern.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } smul_state_t;

endpackage

// File: rtl/smul_adder.sv
module smul_adder #(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] part_i,
  input  logic [OPW-1:0] mcand_i,
  output logic [OPW:0]   sum_o
);

  always_comb begin
    sum_o = {1'b0, part_i} + {1'b0, mcand_i};
  end

endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
  parameter int OPW = 4,
  localparam int ACCW = 2 * OPW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic            ad,
  input  logic            sh,
  input  logic [OPW-1:0]  mcand_in,
  input  logic [OPW-1:0]  mplier_in,
  output logic [ACCW-1:0] acc_o,
  output logic [OPW-1:0]  mcand_o
);

  logic [ACCW-1:0] acc_q;
  logic [OPW-1:0]  mcand_q;
  logic [OPW:0]    sum_w;

  smul_adder #(.OPW(OPW)) adder_i (
    .part_i  (acc_q[2*OPW-1:OPW]),
    .mcand_i (mcand_q),
    .sum_o   (sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (ld) begin
      acc_q   <= {{(OPW+1){1'b0}}, mplier_in};
      mcand_q <= mcand_in;
    end else if (ad) begin
      acc_q[ACCW-1:OPW] <= sum_w;
    end else if (sh) begin
      acc_q <= {1'b0, acc_q[ACCW-1:1]};
    end
  end

  assign acc_o   = acc_q;
  assign mcand_o = mcand_q;

endmodule

// File: rtl/smul_step_counter.sv
module smul_step_counter #(
  parameter int OPW = 4,
  localparam int CW = (OPW > 1) ? $clog2(OPW) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = step && (cnt_q == CW'(OPW - 1));

endmodule

// File: rtl/smul_seq.sv
module smul_seq
  import smul_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic lsb,
  input  logic last,
  output logic ld,
  output logic ad,
  output logic sh,
  output logic done
);

  smul_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    ld   = 1'b0;
    ad   = 1'b0;
    sh   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld   = 1'b1;
          st_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (lsb) begin
          ad   = 1'b1;
          st_d = ST_SHIFT;
        end else begin
          sh   = 1'b1;
          st_d = last ? ST_DONE : ST_SCAN;
        end
      end
      ST_SHIFT: begin
        sh   = 1'b1;
        st_d = last ? ST_DONE : ST_SCAN;
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign done = (st_q == ST_DONE);

endmodule

// File: rtl/smul_top.sv
module smul_top #(
  parameter int OPW = 4,
  localparam int ACCW = 2 * OPW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPW-1:0]   mcand_in,
  input  logic [OPW-1:0]   mplier_in,
  output logic [2*OPW-1:0] product,
  output logic             done
);

  logic            ld_w, ad_w, sh_w, last_w;
  logic [ACCW-1:0] acc_w;
  logic [OPW-1:0]  mcand_w;

  smul_seq seq_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .lsb   (acc_w[0]),
    .last  (last_w),
    .ld    (ld_w),
    .ad    (ad_w),
    .sh    (sh_w),
    .done  (done)
  );

  smul_step_counter #(.OPW(OPW)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (ld_w),
    .step   (sh_w),
    .last_o (last_w)
  );

  smul_accum #(.OPW(OPW)) acc_i (
    .clk       (clk),
    .rst       (rst),
    .ld        (ld_w),
    .ad        (ad_w),
    .sh        (sh_w),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .acc_o     (acc_w),
    .mcand_o   (mcand_w)
  );

  assign product = acc_w[2*OPW-1:0];

endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
  parameter int OPW = 4,
  localparam int ACCW = 2 * OPW + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            ld,
  input logic            ad,
  input logic            sh,
  input logic            last,
  input logic            done,
  input logic [ACCW-1:0] acc,
  input logic [OPW-1:0]  mcand
);

  a_r3_load_clears_upper: assert property (@(posedge clk) disable iff (rst)
    ld |=> acc[ACCW-1:OPW] == '0);

  a_r3_mcand_held: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(mcand));

  a_r4_add_upper: assert property (@(posedge clk) disable iff (rst)
    ad |=> (acc[ACCW-1:OPW] == ({1'b0, $past(acc[2*OPW-1:OPW])} + {1'b0, $past(mcand)}))
           && (acc[OPW-1:0] == $past(acc[OPW-1:0])));

  a_r5_shift_right: assert property (@(posedge clk) disable iff (rst)
    sh |=> acc == ($past(acc) >> 1));

  a_r6_add_then_shift: assert property (@(posedge clk) disable iff (rst)
    ad |=> sh);

  a_r6_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld, ad, sh}));

  a_r7_last_to_done: assert property (@(posedge clk) disable iff (rst)
    last |=> done);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind smul_top smul_checker #(.OPW(OPW)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .ld    (ld_w),
  .ad    (ad_w),
  .sh    (sh_w),
  .last  (last_w),
  .done  (done),
  .acc   (acc_w),
  .mcand (mcand_w)
);

// File: tb/smul_top_tb_top.sv
module smul_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] mcand_in = '0;
  logic [3:0] mplier_in = '0;
  logic [7:0] product;
  logic       done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  smul_top #(.OPW(4)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .product   (product),
    .done      (done)
  );

  // {multiplicand, multiplier, product}
  localparam logic [15:0] VEC [8] = '{
    {4'd0,  4'd0,  8'd0},
    {4'd1,  4'd1,  8'd1},
    {4'd15, 4'd15, 8'd225},
    {4'd15, 4'd0,  8'd0},
    {4'd0,  4'd15, 8'd0},
    {4'd9,  4'd6,  8'd54},
    {4'd7,  4'd8,  8'd56},
    {4'd12, 4'd5,  8'd60}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // start a run at a negedge; returns with the bench at the negedge after done
  task automatic run(input logic [3:0] a, input logic [3:0] b, input bit disturb,
                     output int lat);
    @(negedge clk);
    mcand_in = a; mplier_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      if (disturb && lat == 2) begin
        start = 1'b1; mcand_in = ~a; mplier_in = ~b;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && product == 8'd0, "R1 reset", product, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && product == 8'd0, "R1 after reset", product, 0);

    // R3: load image visible one edge after start
    @(negedge clk);
    mcand_in = 4'd15; mplier_in = 4'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(product == 8'h01, "R3 load image", product, 8'h01);
    @(negedge clk);
    chk(product == 8'hF1, "R4 add into upper", product, 8'hF1);
    @(negedge clk);
    chk(product == 8'h78, "R5 shift right", product, 8'h78);
    while (!done) @(negedge clk);
    chk(product == 8'd15, "R2 15x1", product, 15);

    // R4/R5 carry path for 15 x 15
    @(negedge clk);
    mcand_in = 4'd15; mplier_in = 4'd15; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(product == 8'h0F, "R3 load 15", product, 8'h0F);
    @(negedge clk);
    chk(product == 8'hFF, "R4 first add", product, 8'hFF);
    repeat (3) @(negedge clk);
    chk(product == 8'hB7, "R5 carry shifted down", product, 8'hB7);
    while (!done) @(negedge clk);
    chk(product == 8'd225, "R2 15x15", product, 225);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      run(VEC[i][15:12], VEC[i][11:8], 1'b0, lat);
      chk(product == VEC[i][7:0], "R2 table", product, VEC[i][7:0]);
      chk(lat == 4 + $countones(VEC[i][11:8]), "R6 table latency", lat,
          4 + $countones(VEC[i][11:8]));
    end

    // exhaustive sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run(4'(a), 4'(b), 1'b0, lat);
        chk(product == 8'(a * b), "R2 sweep", product, a * b);
        chk(lat == 4 + $countones(4'(b)), "R6 sweep latency", lat, 4 + $countones(4'(b)));
        @(negedge clk);
        chk(done == 1'b0, "R7 back to idle", done, 0);
      end
    end

    // R8: start and operand changes mid-run are ignored
    run(4'd11, 4'd13, 1'b1, lat);
    chk(product == 8'd143, "R8 busy start ignored", product, 143);
    chk(lat == 7, "R8 timing unchanged", lat, 7);

    // R9: product holds, done stays low
    mcand_in = 4'd3; mplier_in = 4'd3;
    repeat (6) begin
      @(negedge clk);
      chk(product == 8'd143 && done == 1'b0, "R9 hold after done", product, 143);
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule